// File: doc/BRIEF.md
# I/Q Bit-Lane Stream Serializer

This block takes quantised I/Q samples, one per accepted strobe on its sample input, and turns them into a single serial bit stream. Each 2-bit I code and 2-bit Q code is first translated into four lane bits according to a selectable number format. Lane 0 carries the I sign-like (upper) bit, lane 1 the I lower bit, lane 2 the Q upper bit and lane 3 the Q lower bit. Sixteen consecutive samples make a group. A finished group is handed as a whole to an output bank. The output bank then emits one 16-bit segment per selected lane, with the oldest sample of each segment first.

The sample input is a valid/ready port whose ready is held high: the block never back-pressures the sample source. The serial output is a valid/ready port that the consumer may stall at any time. The bank holds one finished group while the next group is being collected. A group that completes while the bank is still busy is discarded, and a sticky overrun flag records the loss. For lossless operation the consumer must take at least 2 bits per sample in two-lane modes and 4 bits per sample in four-lane mode.

Top module: `iq_lane_serializer`

## Requirements
- R1: After reset `m_valid` is 0 and `overrun` is 0.
- R2: With `fmt`=0 (sign/magnitude), the input code c in 0..3 stands for the level 2c-3. The upper lane bit is 1 for a negative level, and the lower lane bit is 1 when the magnitude is 3.
- R3: With `fmt`=1 (unsigned) or `fmt`=3, the lane bits are the code's bits, upper then lower. With `fmt`=2 (two's complement), the lane bits are the 2-bit two's-complement form of c-2.
- R4: `mode` selects the lanes that are streamed, in the order given: 0 streams lane 0; 1 streams lanes 0,1; 2 streams lanes 0,2; 3 streams lanes 0,1,2,3.
- R5: Each lane segment is 16 bits long and carries samples 0..15 of its group, sample 0 first. `m_first` is 1 exactly on the first bit of each segment.
- R6: While `m_valid`=1 and `m_ready`=0, `m_valid`, `m_data` and `m_first` keep their values on the next cycle.
- R7: If the output bank is free, or frees on that same edge, the group loads on the edge that accepts its 16th sample. The group's first bit appears on the output one cycle later. Collection of the next group carries on meanwhile, so a consumer at exactly the minimum bit rate loses nothing.
- R8: A group that completes while the bank is still busy is dropped, and `overrun` is set. Once set, `overrun` stays 1 until reset.
- R9: The lane selection of a group is the `mode` value present with the group's first sample. Later changes of `mode` apply from the next group.
- R10: `s_ready` is always 1; every `s_valid` cycle accepts one sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Lane-set selector |
| fmt | input | 2 | Sample number format selector |
| s_valid | input | 1 | Sample strobe |
| s_ready | output | 1 | Sample accept, constant 1 |
| s_i | input | 2 | I quantiser code |
| s_q | input | 2 | Q quantiser code |
| m_valid | output | 1 | Serial bit available |
| m_ready | input | 1 | Consumer takes the bit |
| m_data | output | 1 | Serial bit |
| m_first | output | 1 | First bit of a lane segment |
| overrun | output | 1 | Sticky lost-group flag |

## Verification
The hardest case to reach from the ports is the handover at exactly the minimum bit rate. There, the last bit of one group leaves on the same edge that completes the next group. A one-cycle slip in either direction turns that edge into a false overrun or a merged stream. The stimulus reaches it by strobing samples every fourth cycle in four-lane mode with the consumer always ready, two groups back to back. The real overrun is reached by holding `m_ready` low across two full groups, which also exercises the stall hold.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    LS_B0  = 2'd0,
    LS_B01 = 2'd1,
    LS_B02 = 2'd2,
    LS_ALL = 2'd3
  } lane_set_e;

  typedef enum logic [1:0] {
    FM_SIGNMAG  = 2'd0,
    FM_UNSIGNED = 2'd1,
    FM_TWOS     = 2'd2,
    FM_RSVD     = 2'd3
  } fmt_e;

  // index of the last slot used by a lane set
  function automatic logic [1:0] last_slot(lane_set_e m);
    case (m)
      LS_B0:   return 2'd0;
      LS_B01:  return 2'd1;
      LS_B02:  return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

  // physical lane streamed in a given slot
  function automatic logic [1:0] slot_lane(lane_set_e m, logic [1:0] s);
    case (m)
      LS_B0:   return 2'd0;
      LS_B02:  return {s[0], 1'b0};
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/iq_code_mapper.sv
module iq_code_mapper
  import ssr_pkg::*;
(
  input  fmt_e        fmt,
  input  logic [1:0]  code_i,
  input  logic [1:0]  code_q,
  output logic [LANES-1:0] lanes
);
  // returns {lower, upper}
  function automatic logic [1:0] map_code(fmt_e f, logic [1:0] c);
    logic up, lo;
    case (f)
      FM_SIGNMAG: begin
        up = ~c[1];
        lo = c[1] ? c[0] : ~c[0];
      end
      FM_TWOS: begin
        up = ~c[1];
        lo = c[0];
      end
      default: begin
        up = c[1];
        lo = c[0];
      end
    endcase
    return {lo, up};
  endfunction

  logic [1:0] i_bits, q_bits;
  always_comb begin
    i_bits = map_code(fmt, code_i);
    q_bits = map_code(fmt, code_q);
    lanes  = {q_bits, i_bits};
  end
endmodule

// File: rtl/iq_group_collector.sv
module iq_group_collector
  import ssr_pkg::*;
#(
  parameter int SEG_LEN = 16,
  localparam int CNT_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic [LANES-1:0]              lanes,
  input  lane_set_e                     mode,
  output logic                          grp_done,
  output logic [LANES-1:0][SEG_LEN-1:0] grp_bits,
  output lane_set_e                     grp_mode
);
  logic [LANES-1:0][SEG_LEN-1:0] acc;
  logic [CNT_W-1:0]              cnt;
  lane_set_e                     mode_q;

  always_comb begin
    grp_bits = acc;
    for (int l = 0; l < LANES; l++) grp_bits[l][cnt] = lanes[l];
    grp_done = take && (cnt == CNT_W'(SEG_LEN - 1));
    grp_mode = (cnt == '0) ? mode : mode_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      cnt    <= '0;
      mode_q <= LS_B0;
    end else if (take) begin
      acc <= grp_bits;
      cnt <= grp_done ? '0 : cnt + 1'b1;
      if (cnt == '0) mode_q <= mode;
    end
  end
endmodule

// File: rtl/iq_lane_shifter.sv
module iq_lane_shifter
  import ssr_pkg::*;
#(
  parameter int SEG_LEN = 16,
  localparam int BIT_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [LANES-1:0][SEG_LEN-1:0] load_bits,
  input  lane_set_e                     load_mode,
  input  logic                          m_ready,
  output logic                          m_valid,
  output logic                          m_data,
  output logic                          m_first,
  output logic                          free
);
  logic [LANES-1:0][SEG_LEN-1:0] bank;
  lane_set_e                     mode_q;
  logic                          full;
  logic [1:0]                    slot;
  logic [BIT_W-1:0]              bitx;
  logic [1:0]                    lane;
  logic                          fire, at_last_bit, at_last_slot;

  always_comb begin
    lane         = slot_lane(mode_q, slot);
    fire         = full && m_ready;
    at_last_bit  = (bitx == BIT_W'(SEG_LEN - 1));
    at_last_slot = (slot == last_slot(mode_q));
    free         = !full || (fire && at_last_bit && at_last_slot);
    m_valid      = full;
    m_data       = full && bank[lane][bitx];
    m_first      = full && (bitx == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank   <= '0;
      mode_q <= LS_B0;
      full   <= 1'b0;
      slot   <= '0;
      bitx   <= '0;
    end else if (load) begin
      bank   <= load_bits;
      mode_q <= load_mode;
      full   <= 1'b1;
      slot   <= '0;
      bitx   <= '0;
    end else if (fire) begin
      if (at_last_bit) begin
        bitx <= '0;
        if (at_last_slot) full <= 1'b0;
        else              slot <= slot + 1'b1;
      end else begin
        bitx <= bitx + 1'b1;
      end
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_first)));

  // R5
  first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_first) |=> !m_first);
endmodule

// File: rtl/iq_lane_serializer.sv
module iq_lane_serializer
  import ssr_pkg::*;
#(
  parameter int SEG_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [1:0] fmt,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic [1:0] s_i,
  input  logic [1:0] s_q,
  output logic       m_valid,
  input  logic       m_ready,
  output logic       m_data,
  output logic       m_first,
  output logic       overrun
);
  logic [LANES-1:0]              lanes;
  logic                          grp_done, free, load;
  logic [LANES-1:0][SEG_LEN-1:0] grp_bits;
  lane_set_e                     grp_mode;

  assign s_ready = 1'b1;
  assign load    = grp_done && free;

  iq_code_mapper u_map (
    .fmt    (fmt_e'(fmt)),
    .code_i (s_i),
    .code_q (s_q),
    .lanes  (lanes)
  );

  iq_group_collector #(.SEG_LEN(SEG_LEN)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (s_valid),
    .lanes    (lanes),
    .mode     (lane_set_e'(mode)),
    .grp_done (grp_done),
    .grp_bits (grp_bits),
    .grp_mode (grp_mode)
  );

  iq_lane_shifter #(.SEG_LEN(SEG_LEN)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_bits (grp_bits),
    .load_mode (grp_mode),
    .m_ready   (m_ready),
    .m_valid   (m_valid),
    .m_data    (m_data),
    .m_first   (m_first),
    .free      (free)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   overrun <= 1'b0;
    else if (grp_done && !free)   overrun <= 1'b1;
  end

  // R7
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_done && free) |=> (m_valid && m_first));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_done && !free) |=> overrun);
endmodule

// File: tb/iq_lane_serializer_bench.sv
`timescale 1ns/1ps
module iq_lane_serializer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0, fmt = 2'd0, s_i = 2'd0, s_q = 2'd0;
  logic       s_valid = 1'b0, m_ready = 1'b0;
  logic       s_ready, m_valid, m_data, m_first, overrun;

  int n_total = 0, n_fail = 0;
  bit finished = 0;

  logic rec_d [0:255];
  logic rec_f [0:255];
  int   rec_n = 0;
  logic exp_d [0:255];
  logic exp_f [0:255];
  int   exp_n = 0;

  always #2.5 clk = ~clk;

  iq_lane_serializer u_iq_lane_serializer (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fmt(fmt),
    .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i), .s_q(s_q),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_first(m_first), .overrun(overrun)
  );

  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready && rec_n < 256) begin
      rec_d[rec_n] = m_data;
      rec_f[rec_n] = m_first;
      rec_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // lane bits {q_lo,q_up,i_lo,i_up} from the format rules
  function automatic logic [3:0] ref_lanes(input logic [1:0] f, input logic [1:0] ci, input logic [1:0] cq);
    logic [1:0] r [2];
    logic [1:0] c [2];
    c[0] = ci; c[1] = cq;
    for (int ch = 0; ch < 2; ch++) begin
      int lvl = 2 * int'(c[ch]) - 3;
      logic [1:0] tc = 2'(int'(c[ch]) - 2);
      case (f)
        2'd0: r[ch] = {(lvl == 3 || lvl == -3), (lvl < 0)};
        2'd2: r[ch] = {tc[0], tc[1]};
        default: r[ch] = {c[ch][0], c[ch][1]};
      endcase
    end
    return {r[1], r[0]};
  endfunction

  function automatic int lane_of(input logic [1:0] m, input int s);
    case (m)
      2'd0: return 0;
      2'd2: return s * 2;
      default: return s;
    endcase
  endfunction

  function automatic int n_slots(input logic [1:0] m);
    case (m)
      2'd0: return 1;
      2'd3: return 4;
      default: return 2;
    endcase
  endfunction

  task automatic add_expected(input logic [1:0] m, input logic [3:0] lb [16]);
    for (int s = 0; s < n_slots(m); s++)
      for (int k = 0; k < 16; k++) begin
        exp_d[exp_n] = lb[k][lane_of(m, s)];
        exp_f[exp_n] = (k == 0);
        exp_n++;
      end
  endtask

  task automatic drive_sample(input logic [1:0] ci, input logic [1:0] cq);
    s_valid = 1'b1; s_i = ci; s_q = cq;
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  // sends one group; mode switches to m_late after sample sw_at
  task automatic send_group(input logic [1:0] m, input logic [1:0] m_late, input int sw_at,
                            input logic [1:0] f, input int gap, input int seed, input bit record);
    logic [3:0] lb [16];
    fmt = f;
    for (int k = 0; k < 16; k++) begin
      logic [1:0] ci = 2'((k + seed) % 4);
      logic [1:0] cq = 2'((3 * k + 2 * seed + 1) % 4);
      mode = (k < sw_at) ? m : m_late;
      lb[k] = ref_lanes(f, ci, cq);
      drive_sample(ci, cq);
      repeat (gap - 1) begin @(posedge clk); #1; end
    end
    if (record) add_expected(m, lb);
  endtask

  task automatic drain_compare(input string req);
    int bad = 0, badf = 0, first_bad = -1;
    repeat (300) begin @(posedge clk); #1; end
    chk(rec_n == exp_n, req, rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      if (rec_d[i] !== exp_d[i]) begin bad++; if (first_bad < 0) first_bad = i; end
      if (rec_f[i] !== exp_f[i]) badf++;
    end
    chk(bad == 0, {req, " data bits"}, first_bad, -1);
    chk(badf == 0, {req, " R5 first markers"}, badf, 0);
    rec_n = 0; exp_n = 0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
    repeat (3) begin @(posedge clk); #1; end
    rst_n = 1'b1;
    rec_n = 0; exp_n = 0;
  endtask

  task automatic t_reset;
    do_reset();
    @(negedge clk);
    chk(m_valid == 1'b0, "R1 m_valid after reset", m_valid, 0);
    chk(overrun == 1'b0, "R1 overrun after reset", overrun, 0);
    chk(s_ready == 1'b1, "R10 s_ready", s_ready, 1);
    @(posedge clk); #1;
  endtask

  task automatic t_latency;
    logic [3:0] lb [16];
    m_ready = 1'b0; mode = 2'd3; fmt = 2'd0;
    for (int k = 0; k < 16; k++) begin
      logic [1:0] ci = 2'(3 - (k % 4));
      logic [1:0] cq = 2'(k % 4);
      lb[k] = ref_lanes(2'd0, ci, cq);
      if (k == 15) begin
        s_valid = 1'b1; s_i = ci; s_q = cq;
        @(negedge clk);
        chk(m_valid == 1'b0, "R7 not valid before 16th sample", m_valid, 0);
        @(posedge clk); #1; s_valid = 1'b0;
        @(negedge clk);
        chk(m_valid == 1'b1, "R7 valid after 16th sample", m_valid, 1);
        chk(m_first == 1'b1, "R5 first marker on bit 0", m_first, 1);
        chk(m_data == lb[0][0], "R2 lane0 sample0 sign/mag", m_data, lb[0][0]);
        @(posedge clk); #1;
      end else begin
        drive_sample(ci, cq);
      end
    end
    add_expected(2'd3, lb);
    m_ready = 1'b1;
    drain_compare("R2 R4 mode3 sign/mag");
  endtask

  task automatic t_modes;
    m_ready = 1'b1;
    send_group(2'd0, 2'd0, 16, 2'd1, 3, 1, 1);
    drain_compare("R4 R3 mode0 unsigned");
    send_group(2'd1, 2'd1, 16, 2'd2, 3, 2, 1);
    drain_compare("R4 R3 mode1 two's complement");
    send_group(2'd2, 2'd2, 16, 2'd0, 3, 3, 1);
    drain_compare("R4 R2 mode2 sign/mag");
    send_group(2'd3, 2'd3, 16, 2'd3, 5, 0, 1);
    drain_compare("R3 mode3 fmt=3 as unsigned");
  endtask

  task automatic t_back_to_back;
    m_ready = 1'b1;
    send_group(2'd3, 2'd3, 16, 2'd2, 4, 5, 1);
    send_group(2'd3, 2'd3, 16, 2'd0, 4, 6, 1);
    drain_compare("R7 back-to-back at minimum rate");
    chk(overrun == 1'b0, "R7 no overrun at minimum rate", overrun, 0);
  endtask

  task automatic t_mode_switch;
    m_ready = 1'b1;
    send_group(2'd1, 2'd3, 8, 2'd1, 3, 7, 1);
    send_group(2'd3, 2'd3, 16, 2'd1, 5, 8, 1);
    drain_compare("R9 mode latched at group start");
  endtask

  task automatic t_stall_overrun;
    logic d0, f0;
    m_ready = 1'b0;
    send_group(2'd1, 2'd1, 16, 2'd0, 2, 9, 1);
    @(negedge clk);
    d0 = m_data; f0 = m_first;
    repeat (10) @(negedge clk);
    chk(m_valid == 1'b1, "R6 valid held in stall", m_valid, 1);
    chk(m_data == d0, "R6 data held in stall", m_data, d0);
    chk(m_first == f0, "R6 first held in stall", m_first, f0);
    chk(overrun == 1'b0, "R8 no overrun yet", overrun, 0);
    @(posedge clk); #1;
    send_group(2'd3, 2'd3, 16, 2'd0, 2, 10, 0);
    @(negedge clk);
    chk(overrun == 1'b1, "R8 overrun on busy bank", overrun, 1);
    m_ready = 1'b1;
    drain_compare("R8 dropped group not emitted");
    chk(overrun == 1'b1, "R8 overrun sticky after drain", overrun, 1);
    do_reset();
    @(negedge clk);
    chk(overrun == 1'b0, "R1 overrun cleared by reset", overrun, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_modes();
    t_back_to_back();
    t_mode_switch();
    t_stall_overrun();
    finished = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule